// File: doc/BRIEF.md
# Exception acceptance and return controller

This CPU-side control unit decides, each clock, what happens to incoming general exceptions, ordinary interrupts and nonmaskable interrupts. The decision depends on the block bit held in the status register (SR). When the block bit is clear, an event is accepted. The current PC goes to the saved-PC register, the current SR goes to the saved-SR register, the block bit is set, and fetch is redirected to the handler vector. When the block bit is set, an ordinary interrupt is deferred. A nonmaskable interrupt is deferred or accepted according to a software policy input. A general exception forces a manual-reset request and a jump to the reset address.

A return command copies the saved SR back into SR and redirects fetch to the saved PC. Deferred requests sit in pending flags. They are taken in the first cycle in which the block bit reads clear. A user-break request never escalates and is only forwarded on its own output. All outputs are registered, so a decision made on the inputs of one cycle appears after the next rising edge.

Top module: `trap_ctrl`

## Requirements
- R1: With SR bit 28 (the block bit) clear, a general exception request is accepted. One cycle later `redir_o`=1, `redir_pc_o`=`vec_i` and `cause_o`=2. Cause codes: 0 none, 1 NMI, 2 general exception, 3 interrupt, 4 return, 5 escalation.
- R2: With the block bit set, a general exception request gives, one cycle later, `mrst_o`=1, `cause_o`=5 and `redir_pc_o`=0xA0000000, with SR at its reset value 0x700000F0. All pending flags are cleared, and any other request in that cycle is discarded.
- R3: With the block bit set, an ordinary interrupt request is latched pending. It is accepted (cause 3) in the first cycle after the block bit reads 0.
- R4: With the block bit set, an NMI is held pending while `nmi_take_i`=0. It is accepted (cause 1) in any cycle in which `nmi_take_i`=1.
- R5: A return command sets SR to the saved SR and redirects to the saved PC with cause 4, in one step.
- R6: `ubrk_o` follows `ubrk_req_i` one cycle later. A user break causes neither escalation nor any change of SR or the pending flags.
- R7: On acceptance, the saved PC takes `pc_i`, the saved SR takes the pre-acceptance SR, and the block bit is set.
- R8: Among simultaneous events the order is: escalation, NMI, general exception, interrupt, return, SR write. A losing request stays pending. A losing return or SR write is dropped.
- R9: A pending interrupt is accepted in the cycle right after a return that restores an SR with the block bit clear.
- R10: `srst_i` clears all pending flags and outputs, sets SR to 0x700000F0 and clears the saved registers, overriding every other input.
- R11: `sr_we_i` loads SR from `sr_wdata_i` when no other event acts in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous reset |
| exc_req_i | input | 1 | General exception request |
| ubrk_req_i | input | 1 | User-break exception request |
| irq_req_i | input | 1 | Ordinary interrupt request |
| nmi_req_i | input | 1 | Nonmaskable interrupt request |
| nmi_take_i | input | 1 | NMI policy while blocked: 1 accept, 0 hold |
| ret_i | input | 1 | Return-from-exception command |
| sr_we_i | input | 1 | Software SR write strobe |
| sr_wdata_i | input | 32 | Software SR write data |
| pc_i | input | 32 | Current program counter |
| vec_i | input | 32 | Handler vector |
| sr_o | output | 32 | Current SR |
| spc_o | output | 32 | Saved PC |
| ssr_o | output | 32 | Saved SR |
| redir_o | output | 1 | Fetch redirect strobe |
| redir_pc_o | output | 32 | Redirect target |
| cause_o | output | 3 | Event class of the redirect |
| mrst_o | output | 1 | Manual-reset request |
| ubrk_o | output | 1 | Forwarded user-break request |

## Verification
The assertions assume that `srst_i` is a level sampled on clock edges, and that the saved-state checks are not hidden by a synchronous reset in the same cycle. The controller resolves that case itself by letting the reset win. They also assume nothing about exclusivity among requests. The stimulus therefore drives arbitrary overlaps of requests, returns and SR writes, changed only at falling edges. Synchronous resets are sparse, so that long runs of blocked and pending states occur between them.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {
    CS_NONE = 3'd0,
    CS_NMI  = 3'd1,
    CS_EXC  = 3'd2,
    CS_IRQ  = 3'd3,
    CS_RET  = 3'd4,
    CS_ESC  = 3'd5
  } cause_e;

  localparam int unsigned NSRC    = 3;
  localparam int unsigned IDX_NMI = 0;
  localparam int unsigned IDX_EXC = 1;
  localparam int unsigned IDX_IRQ = 2;
endpackage

// File: rtl/trap_arb.sv
module trap_arb
  import trap_pkg::*;
(
  input  logic            srst_i,
  input  logic            bl_i,
  input  logic            nmi_take_i,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] pend_i,
  input  logic            ret_i,
  input  logic            we_i,
  output logic            esc_o,
  output logic            acc_o,
  output logic            ret_o,
  output logic            wr_o,
  output logic [NSRC-1:0] grant_o,
  output cause_e          cause_o
);
  logic [NSRC-1:0] eff;
  logic            live;

  assign eff  = req_i | pend_i;
  assign live = !srst_i;

  // only a fresh exception escalates; a pending one waits for the bit to clear
  assign esc_o = live && req_i[IDX_EXC] && bl_i;

  always_comb begin
    grant_o = '0;
    if (live && !esc_o) begin
      if (eff[IDX_NMI] && (!bl_i || nmi_take_i))
        grant_o[IDX_NMI] = 1'b1;
      else if (eff[IDX_EXC] && !bl_i)
        grant_o[IDX_EXC] = 1'b1;
      else if (eff[IDX_IRQ] && !bl_i)
        grant_o[IDX_IRQ] = 1'b1;
    end
  end

  assign acc_o = |grant_o;
  assign ret_o = live && !esc_o && !acc_o && ret_i;
  assign wr_o  = live && !esc_o && !acc_o && !ret_i && we_i;

  always_comb begin
    cause_o = CS_NONE;
    if (esc_o)                 cause_o = CS_ESC;
    else if (grant_o[IDX_NMI]) cause_o = CS_NMI;
    else if (grant_o[IDX_EXC]) cause_o = CS_EXC;
    else if (grant_o[IDX_IRQ]) cause_o = CS_IRQ;
    else if (ret_o)            cause_o = CS_RET;
  end
endmodule

// File: rtl/trap_pend.sv
module trap_pend
  import trap_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] grant_i,
  output logic [NSRC-1:0] pend_o
);
  for (genvar k = 0; k < NSRC; k++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         q <= 1'b0;
      else if (flush_i)    q <= 1'b0;
      else if (grant_i[k]) q <= 1'b0;
      else if (req_i[k])   q <= 1'b1;
    end
    assign pend_o[k] = q;
  end
endmodule

// File: rtl/trap_ctx.sv
module trap_ctx #(
  parameter int unsigned W      = 32,
  parameter int unsigned BL_POS = 28,
  parameter logic [W-1:0] SR_RST = 32'h7000_00F0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic         esc_i,
  input  logic         acc_i,
  input  logic         ret_i,
  input  logic         wr_i,
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] sr_o,
  output logic [W-1:0] spc_o,
  output logic [W-1:0] ssr_o
);
  logic [W-1:0] sr_q, spc_q, ssr_q;
  logic [W-1:0] bl_mask;

  assign bl_mask = {{(W-1){1'b0}}, 1'b1} << BL_POS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= SR_RST;
      spc_q <= '0;
      ssr_q <= '0;
    end else if (srst_i) begin
      sr_q  <= SR_RST;
      spc_q <= '0;
      ssr_q <= '0;
    end else if (esc_i) begin
      sr_q  <= SR_RST;
    end else if (acc_i) begin
      spc_q <= pc_i;
      ssr_q <= sr_q;
      sr_q  <= sr_q | bl_mask;
    end else if (ret_i) begin
      sr_q  <= ssr_q;
    end else if (wr_i) begin
      sr_q  <= wdata_i;
    end
  end

  assign sr_o  = sr_q;
  assign spc_o = spc_q;
  assign ssr_o = ssr_q;

  AST_ACC_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> (spc_q == $past(pc_i)) && (ssr_q == $past(sr_q)) && sr_q[BL_POS]); // R7
  AST_RET_SR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i |=> sr_q == $past(ssr_q)); // R5
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int unsigned W         = 32,
  parameter int unsigned BL_POS    = 28,
  parameter logic [W-1:0] SR_RST    = 32'h7000_00F0,
  parameter logic [W-1:0] RESET_VEC = 32'hA000_0000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic         exc_req_i,
  input  logic         ubrk_req_i,
  input  logic         irq_req_i,
  input  logic         nmi_req_i,
  input  logic         nmi_take_i,
  input  logic         ret_i,
  input  logic         sr_we_i,
  input  logic [W-1:0] sr_wdata_i,
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] vec_i,
  output logic [W-1:0] sr_o,
  output logic [W-1:0] spc_o,
  output logic [W-1:0] ssr_o,
  output logic         redir_o,
  output logic [W-1:0] redir_pc_o,
  output logic [2:0]   cause_o,
  output logic         mrst_o,
  output logic         ubrk_o
);
  logic [NSRC-1:0] req, pend, grant;
  logic            esc, acc, ret_go, wr_go, bl;
  cause_e          cause;
  logic [W-1:0]    tgt;

  assign req[IDX_NMI] = nmi_req_i;
  assign req[IDX_EXC] = exc_req_i;
  assign req[IDX_IRQ] = irq_req_i;
  assign bl = sr_o[BL_POS];

  trap_arb u_arb (
    .srst_i     (srst_i),
    .bl_i       (bl),
    .nmi_take_i (nmi_take_i),
    .req_i      (req),
    .pend_i     (pend),
    .ret_i      (ret_i),
    .we_i       (sr_we_i),
    .esc_o      (esc),
    .acc_o      (acc),
    .ret_o      (ret_go),
    .wr_o       (wr_go),
    .grant_o    (grant),
    .cause_o    (cause)
  );

  trap_pend u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (srst_i || esc),
    .req_i   (req),
    .grant_i (grant),
    .pend_o  (pend)
  );

  trap_ctx #(.W(W), .BL_POS(BL_POS), .SR_RST(SR_RST)) u_ctx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_i  (srst_i),
    .esc_i   (esc),
    .acc_i   (acc),
    .ret_i   (ret_go),
    .wr_i    (wr_go),
    .pc_i    (pc_i),
    .wdata_i (sr_wdata_i),
    .sr_o    (sr_o),
    .spc_o   (spc_o),
    .ssr_o   (ssr_o)
  );

  always_comb begin
    tgt = '0;
    if (esc)         tgt = RESET_VEC;
    else if (acc)    tgt = vec_i;
    else if (ret_go) tgt = spc_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redir_o    <= 1'b0;
      redir_pc_o <= '0;
      cause_o    <= 3'd0;
      mrst_o     <= 1'b0;
      ubrk_o     <= 1'b0;
    end else if (srst_i) begin
      redir_o    <= 1'b0;
      redir_pc_o <= '0;
      cause_o    <= 3'd0;
      mrst_o     <= 1'b0;
      ubrk_o     <= 1'b0;
    end else begin
      redir_o    <= esc || acc || ret_go;
      redir_pc_o <= tgt;
      cause_o    <= cause;
      mrst_o     <= esc;
      ubrk_o     <= ubrk_req_i;
    end
  end

  AST_ESC_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_i && bl && !srst_i) |=> (mrst_o && redir_pc_o == RESET_VEC && sr_o == SR_RST && pend == '0)); // R2
  AST_IRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_i && bl && !srst_i && !exc_req_i) |=> pend[IDX_IRQ]); // R3
  AST_SRST_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (pend == '0) && sr_o[BL_POS] && !redir_o); // R10
  AST_UBRK_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srst_i |=> ubrk_o == $past(ubrk_req_i)); // R6
  AST_ACC_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && !bl && exc_req_i && !nmi_req_i && !pend[IDX_NMI]) |=> (redir_o && redir_pc_o == $past(vec_i) && cause_o == 3'd2)); // R1
endmodule

// File: tb/sim_trap_ctrl.sv
module sim_trap_ctrl;
  localparam int unsigned W = 32;
  localparam logic [31:0] SR_RST = 32'h7000_00F0;
  localparam logic [31:0] RVEC   = 32'hA000_0000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic srst_i = 0, exc_req_i = 0, ubrk_req_i = 0, irq_req_i = 0, nmi_req_i = 0;
  logic nmi_take_i = 0, ret_i = 0, sr_we_i = 0;
  logic [W-1:0] sr_wdata_i = '0, pc_i = '0, vec_i = '0;
  logic [W-1:0] sr_o, spc_o, ssr_o, redir_pc_o;
  logic redir_o, mrst_o, ubrk_o;
  logic [2:0] cause_o;

  trap_ctrl u0 (.*);

  always #4 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_sr = SR_RST, m_spc = 0, m_ssr = 0, m_rpc = 0;
  bit m_ip = 0, m_np = 0, m_ep = 0, m_redir = 0, m_mrst = 0, m_ubrk = 0;
  int m_cause = 0;
  string tag = "R10";
  int last_cause = 0;

  task automatic model_step();
    bit bl, ne, ie, ee;
    int c;
    if (srst_i) begin
      m_sr = SR_RST; m_spc = 0; m_ssr = 0; m_ip = 0; m_np = 0; m_ep = 0;
      m_redir = 0; m_rpc = 0; m_cause = 0; m_mrst = 0; m_ubrk = 0;
      tag = "R10"; last_cause = 0;
      return;
    end
    bl = m_sr[28]; ne = nmi_req_i | m_np; ie = irq_req_i | m_ip; ee = exc_req_i | m_ep;
    m_ubrk = ubrk_req_i; m_mrst = 0; m_redir = 0; m_rpc = 0; c = 0;
    if (exc_req_i && bl) begin
      m_sr = SR_RST; m_ip = 0; m_np = 0; m_ep = 0;
      c = 5; m_redir = 1; m_rpc = RVEC; m_mrst = 1;
    end else if (ne && (!bl || nmi_take_i)) c = 1;
    else if (ee && !bl) c = 2;
    else if (ie && !bl) c = 3;
    if (c >= 1 && c <= 3) begin
      m_spc = pc_i; m_ssr = m_sr; m_sr[28] = 1'b1;
      m_redir = 1; m_rpc = vec_i;
      m_np = (c == 1) ? 1'b0 : ne;
      m_ep = (c == 2) ? 1'b0 : ee;
      m_ip = (c == 3) ? 1'b0 : ie;
    end else if (c == 0) begin
      m_np = ne; m_ep = ee; m_ip = ie;
      if (ret_i) begin
        m_sr = m_ssr; m_redir = 1; m_rpc = m_spc; c = 4;
      end else if (sr_we_i) m_sr = sr_wdata_i;
    end
    case (c)
      5: tag = "R2";
      1: tag = (exc_req_i || irq_req_i) ? "R8" : "R4";
      2: tag = (irq_req_i || ret_i) ? "R8" : "R1";
      3: tag = (last_cause == 4) ? "R9" : "R3";
      4: tag = "R5";
      default: tag = ubrk_req_i ? "R6" : (sr_we_i ? "R11" : "R7");
    endcase
    if (c >= 1 && c <= 3 && tag == "R1") tag = "R7";
    m_cause = c; last_cause = c;
  endtask

  task automatic compare();
    checks++;
    if (sr_o !== m_sr || spc_o !== m_spc || ssr_o !== m_ssr || redir_o !== m_redir ||
        redir_pc_o !== m_rpc || cause_o !== m_cause[2:0] || mrst_o !== m_mrst || ubrk_o !== m_ubrk) begin
      fails++;
      $display("FAIL %s: act sr=%h spc=%h ssr=%h rd=%b pc=%h cs=%0d mr=%b ub=%b exp sr=%h spc=%h ssr=%h rd=%b pc=%h cs=%0d mr=%b ub=%b",
        tag, sr_o, spc_o, ssr_o, redir_o, redir_pc_o, cause_o, mrst_o, ubrk_o,
        m_sr, m_spc, m_ssr, m_redir, m_rpc, m_cause, m_mrst, m_ubrk);
    end
  endtask

  task automatic clr_in();
    srst_i = 0; exc_req_i = 0; ubrk_req_i = 0; irq_req_i = 0; nmi_req_i = 0;
    ret_i = 0; sr_we_i = 0;
  endtask

  // inputs set by caller at negedge; advance one edge and compare
  task automatic tick();
    model_step();
    @(negedge clk_i);
    compare();
    clr_in();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    tag = "R10"; compare();                    // reset state R10
    rst_ni = 1'b1;
    @(negedge clk_i);
    pc_i = 32'h8000_1000; vec_i = 32'h8000_0600;
    sr_we_i = 1; sr_wdata_i = 32'h4000_0000; tick();   // R11 clear block bit
    exc_req_i = 1; tick();                             // R1 / R7
    irq_req_i = 1; pc_i = 32'h8000_2000; tick();       // R3 held (blocked)
    tick();
    ret_i = 1; tick();                                 // R5
    tick();                                            // R9 pending irq taken
    nmi_take_i = 0; nmi_req_i = 1; tick();             // R4 held
    tick();
    nmi_take_i = 1; tick();                            // R4 accepted
    nmi_take_i = 0;
    ubrk_req_i = 1; tick();                            // R6
    tick();
    exc_req_i = 1; irq_req_i = 1; tick();              // R2 escalation
    tick();
    sr_we_i = 1; sr_wdata_i = 32'h0000_00F0; tick();
    nmi_req_i = 1; exc_req_i = 1; irq_req_i = 1; ret_i = 1; tick(); // R8 NMI wins
    sr_we_i = 1; sr_wdata_i = 0; tick();               // R8 return of SR... then pending exc
    tick(); tick();
    srst_i = 1; irq_req_i = 1; exc_req_i = 1; tick();  // R10
    tick();
    for (int n = 0; n < 4000; n++) begin
      exc_req_i  = ($urandom_range(0, 9) == 0);
      irq_req_i  = ($urandom_range(0, 6) == 0);
      nmi_req_i  = ($urandom_range(0, 14) == 0);
      ubrk_req_i = ($urandom_range(0, 9) == 0);
      ret_i      = ($urandom_range(0, 5) == 0);
      sr_we_i    = ($urandom_range(0, 9) == 0);
      sr_wdata_i = $urandom() & 32'hEFFF_FFFF;
      if ($urandom_range(0, 1) == 1) sr_wdata_i[28] = 1'b1;
      nmi_take_i = ($urandom_range(0, 3) == 0);
      srst_i     = ($urandom_range(0, 299) == 0);
      pc_i = $urandom(); vec_i = $urandom();
      tick();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: act running exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule